// File: doc/BRIEF.md
# Instruction-Cache Ramset Register Bank

This block is the register file that software uses to steer two locked, preloadable half-ramsets inside an instruction cache. It sits on a 16-bit word-addressed peripheral bus. For each ramset it holds a control word and a tag word. It also holds one shared status word with two sticky flags. For each ramset it keeps an array of line-valid bits, which the bus can read as packed 16-bit words. A separate fill engine reports each finished line with a one-cycle pulse. The bank turns these pulses into line-valid bits and a derived tag-valid flag.

Two global inputs act through per-ramset masks. The global enable activates each ramset whose enable mask is set. The global clear wipes every ramset whose flush mask is set. The bank catches two kinds of misuse. The first is a register write made while debug mode is active. The second is both tags being programmed to the same region, which also answers the bus with an error. The status flags clear on a normal read. They keep their value when read under emulation, so a debugger can inspect them without side effects.

Top module: `ramset_csr`

## Requirements
- R1: After a synchronous reset, every control, tag and status bit and every line-valid bit reads 0, and `rs_active` is 0.
- R2: A control word (ramset 0 at REG_BASE+0, ramset 1 at REG_BASE+1) has enable mask at bit 0 and flush mask at bit 1, both read/write. Bits 14:2 always read 0. Bit 15 is tag-valid and is read-only: writing 1 to it has no effect.
- R3: `rs_active[n]` is 1 exactly when `cache_en` is 1 and the enable mask of ramset n is 1.
- R4: A tag word (ramset 0 at REG_BASE+2, ramset 1 at REG_BASE+3) stores bits 14:0, and bit 15 reads 0. Writing a tag word clears every line-valid bit and the tag-valid of that ramset.
- R5: While `cache_clr` is 1, each ramset whose flush mask is 1 loses all its line-valid bits and its tag-valid. A ramset whose flush mask is 0 keeps its bits.
- R6: A `fill_done` pulse sets line `fill_line` of ramset `fill_set`. Line L appears at word offset L/16, bit L%16. Ramset 0 words start at LV_BASE and ramset 1 words start at LV_BASE+32. Tag-valid reads 1 exactly when every line of that ramset is valid.
- R7: Status bit 1 is set by any write to a control or tag word while `debug_mode` is 1.
- R8: Writing a tag word with a 15-bit value equal to the other ramset's stored tag does three things. It stores the value, it sets status bit 0 (status word at REG_BASE+4), and it raises `bus_err` in the cycle after the write.
- R9: A status read with `emu_mode` 0 returns the flags and then clears both. With `emu_mode` 1 the flags are returned and kept.
- R10: `bus_rdata` and `bus_rvalid` appear in the cycle after a read request. `bus_rvalid` stays 0 after a write.
- R11: Writes to the line-valid region change nothing and raise `bus_err` in the next cycle. Line-valid words beyond the lines present read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Error response, one cycle after a bad write |
| debug_mode | input | 1 | Debug mode active |
| emu_mode | input | 1 | Emulation access, reads without side effects |
| cache_en | input | 1 | Global cache enable |
| cache_clr | input | 1 | Global cache clear |
| fill_done | input | 1 | One line of a ramset finished filling |
| fill_set | input | 1 | Ramset index of the finished line |
| fill_line | input | $clog2(LINES) | Line index of the finished line |
| rs_active | output | 2 | Per-ramset active indication |

## Verification
The bench builds the bank with LINES = 64, so each ramset occupies four line-valid words. This makes a complete fill take only 64 pulses. It brings the transition of tag-valid from 0 to 1 within reach, and lets the bench read words beyond the last populated one. The defaults for REG_BASE and LV_BASE are kept, so the ramset 1 line-valid words sit at the 32-word stride. A full-width tag and a write with reserved bits set show which bits survive.

// File: rtl/ramset_csr_pkg.sv
package ramset_csr_pkg;

    localparam int DATA_W    = 16;
    localparam int TAG_W     = 15;
    localparam int LV_STRIDE = 32;
    localparam int LVW       = $clog2(LV_STRIDE);
    localparam int REG_COUNT = 5;

    typedef struct packed {
        logic flush;
        logic enable;
    } rs_ctrl_t;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_CTRL,
        KIND_TAG,
        KIND_STAT,
        KIND_LV
    } kind_e;

    typedef struct packed {
        kind_e          kind;
        logic           rs;
        logic [LVW-1:0] word;
    } dec_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input logic tv, input rs_ctrl_t c);
        return {tv, {(DATA_W-3){1'b0}}, c.flush, c.enable};
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input logic dbg, input logic err);
        return {{(DATA_W-2){1'b0}}, dbg, err};
    endfunction

endpackage

// File: rtl/ramset_csr_decode.sv
module ramset_csr_decode
    import ramset_csr_pkg::*;
#(
    parameter logic [15:0] REG_BASE = 16'h1200,
    parameter logic [15:0] LV_BASE  = 16'h1600
) (
    input  logic [15:0] addr,
    output dec_t        dec
);
    logic [15:0] off_reg;
    logic [15:0] off_lv;

    always_comb begin
        off_reg  = addr - REG_BASE;
        off_lv   = addr - LV_BASE;
        dec      = '0;
        dec.kind = KIND_NONE;
        if (off_reg < 16'(REG_COUNT)) begin
            case (off_reg[2:0])
                3'd0: begin dec.kind = KIND_CTRL; dec.rs = 1'b0; end
                3'd1: begin dec.kind = KIND_CTRL; dec.rs = 1'b1; end
                3'd2: begin dec.kind = KIND_TAG;  dec.rs = 1'b0; end
                3'd3: begin dec.kind = KIND_TAG;  dec.rs = 1'b1; end
                default: dec.kind = KIND_STAT;
            endcase
        end else if (off_lv < 16'(2 * LV_STRIDE)) begin
            dec.kind = KIND_LV;
            dec.rs   = off_lv[LVW];
            dec.word = off_lv[LVW-1:0];
        end
    end

endmodule

// File: rtl/ramset_lv_array.sv
module ramset_lv_array
    import ramset_csr_pkg::*;
#(
    parameter int LINES = 512
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     fill_we,
    input  logic [$clog2(LINES)-1:0] fill_line,
    input  logic [LVW-1:0]           rd_word,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     all_valid
);
    localparam int WORDS = LINES / DATA_W;
    localparam int LW    = $clog2(LINES);

    logic [WORDS-1:0][DATA_W-1:0] lv;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lv <= '0;
        end else if (fill_we) begin
            lv[fill_line[LW-1:4]][fill_line[3:0]] <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rd_word == LVW'(w)) rd_data = lv[w];
        end
    end

    assign all_valid = &lv;

    AST_CLEAR_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        clear |=> !all_valid); // R5

endmodule

// File: rtl/ramset_csr_regs.sv
module ramset_csr_regs
    import ramset_csr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 wr_ctrl,
    input  logic [1:0]                 wr_tag,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       rd_stat,
    input  logic                       debug_mode,
    input  logic                       emu_mode,
    output rs_ctrl_t [1:0]             ctrl,
    output logic [1:0][TAG_W-1:0]      tag,
    output logic                       stat_dbg,
    output logic                       stat_err,
    output logic                       tag_clash
);
    logic wr_any;

    assign wr_any    = (|wr_ctrl) || (|wr_tag);
    assign tag_clash = (wr_tag[0] && (wdata[TAG_W-1:0] == tag[1])) ||
                       (wr_tag[1] && (wdata[TAG_W-1:0] == tag[0]));

    generate
        for (genvar n = 0; n < 2; n++) begin : g_rs
            always_ff @(posedge clk) begin
                if (rst) begin
                    ctrl[n] <= '0;
                    tag[n]  <= '0;
                end else begin
                    if (wr_ctrl[n]) ctrl[n] <= rs_ctrl_t'(wdata[1:0]);
                    if (wr_tag[n])  tag[n]  <= wdata[TAG_W-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_dbg <= 1'b0;
            stat_err <= 1'b0;
        end else begin
            if (rd_stat && !emu_mode) begin
                stat_dbg <= 1'b0;
                stat_err <= 1'b0;
            end
            if (wr_any && debug_mode) stat_dbg <= 1'b1;
            if (tag_clash)            stat_err <= 1'b1;
        end
    end

    AST_DEBUG_WRITE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_any && debug_mode) |=> stat_dbg); // R7
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst)
        tag_clash |=> stat_err); // R8
    AST_EMU_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && emu_mode && !wr_any) |=> ($stable(stat_dbg) && $stable(stat_err))); // R9

endmodule

// File: rtl/ramset_csr.sv
module ramset_csr
    import ramset_csr_pkg::*;
#(
    parameter int          LINES    = 512,
    parameter logic [15:0] REG_BASE = 16'h1200,
    parameter logic [15:0] LV_BASE  = 16'h1600
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [15:0]              bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    output logic                     bus_rvalid,
    output logic                     bus_err,
    input  logic                     debug_mode,
    input  logic                     emu_mode,
    input  logic                     cache_en,
    input  logic                     cache_clr,
    input  logic                     fill_done,
    input  logic                     fill_set,
    input  logic [$clog2(LINES)-1:0] fill_line,
    output logic [1:0]               rs_active
);
    dec_t                  dec;
    logic                  rd_req;
    logic                  wr_req;
    logic [1:0]            wr_ctrl;
    logic [1:0]            wr_tag;
    rs_ctrl_t [1:0]        ctrl;
    logic [1:0][TAG_W-1:0] tag;
    logic                  stat_dbg;
    logic                  stat_err;
    logic                  tag_clash;
    logic [1:0]            tv;
    logic [1:0][15:0]      lv_rd;
    logic [15:0]           rd_mux;

    assign rd_req = bus_sel && !bus_we;
    assign wr_req = bus_sel && bus_we;

    ramset_csr_decode #(.REG_BASE(REG_BASE), .LV_BASE(LV_BASE)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    ramset_csr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_tag     (wr_tag),
        .wdata      (bus_wdata),
        .rd_stat    (rd_req && dec.kind == KIND_STAT),
        .debug_mode (debug_mode),
        .emu_mode   (emu_mode),
        .ctrl       (ctrl),
        .tag        (tag),
        .stat_dbg   (stat_dbg),
        .stat_err   (stat_err),
        .tag_clash  (tag_clash)
    );

    generate
        for (genvar n = 0; n < 2; n++) begin : g_rs
            assign wr_ctrl[n]   = wr_req && dec.kind == KIND_CTRL && dec.rs == 1'(n);
            assign wr_tag[n]    = wr_req && dec.kind == KIND_TAG  && dec.rs == 1'(n);
            assign rs_active[n] = cache_en && ctrl[n].enable;

            ramset_lv_array #(.LINES(LINES)) u_lv (
                .clk       (clk),
                .rst       (rst),
                .clear     ((cache_clr && ctrl[n].flush) || wr_tag[n]),
                .fill_we   (fill_done && fill_set == 1'(n)),
                .fill_line (fill_line),
                .rd_word   (dec.word),
                .rd_data   (lv_rd[n]),
                .all_valid (tv[n])
            );
        end
    endgenerate

    always_comb begin
        case (dec.kind)
            KIND_CTRL: rd_mux = ctrl_word(tv[dec.rs], ctrl[dec.rs]);
            KIND_TAG:  rd_mux = {1'b0, tag[dec.rs]};
            KIND_STAT: rd_mux = stat_word(stat_dbg, stat_err);
            KIND_LV:   rd_mux = lv_rd[dec.rs];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
        end else begin
            bus_rdata  <= rd_req ? rd_mux : '0;
            bus_rvalid <= rd_req;
            bus_err    <= wr_req && (tag_clash || dec.kind == KIND_LV);
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> bus_rvalid); // R10
    AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !bus_rvalid); // R10
    AST_ACTIVE_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (|rs_active) |-> cache_en); // R3
    AST_LV_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
        (wr_req && dec.kind == KIND_LV) |=> bus_err); // R11

endmodule

// File: tb/ramset_csr_bench.sv
`timescale 1ns/1ps
module ramset_csr_bench;
    localparam int LINES = 64;
    localparam int LW    = $clog2(LINES);
    localparam logic [15:0] RB  = 16'h1200;
    localparam logic [15:0] LVB = 16'h1600;
    localparam int NV = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0]   bus_addr = '0, bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          bus_rvalid, bus_err;
    logic          debug_mode = 1'b0, emu_mode = 1'b0;
    logic          cache_en = 1'b0, cache_clr = 1'b0;
    logic          fill_done = 1'b0, fill_set = 1'b0;
    logic [LW-1:0] fill_line = '0;
    logic [1:0]    rs_active;

    int checks = 0;
    int fails  = 0;
    logic [15:0] rv;
    logic        ev;

    always #2.5 clk = ~clk;

    ramset_csr #(.LINES(LINES), .REG_BASE(RB), .LV_BASE(LVB)) u_ramset_csr (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err), .debug_mode(debug_mode),
        .emu_mode(emu_mode), .cache_en(cache_en), .cache_clr(cache_clr),
        .fill_done(fill_done), .fill_set(fill_set), .fill_line(fill_line),
        .rs_active(rs_active)
    );

    // vector table: we, addr, wdata, expected (read data or bus_err)
    localparam logic        VW [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [15:0] VA [NV] = '{RB, RB, RB+1, RB+1, RB+2, RB+2, RB+3, RB+3, RB+4};
    localparam logic [15:0] VD [NV] = '{16'hFFFF, 0, 16'h0002, 0, 16'hFABC, 0, 16'h0123, 0, 0};
    localparam logic [15:0] VX [NV] = '{0, 16'h0003, 0, 16'h0002, 0, 16'h7ABC, 0, 16'h0123, 16'h0000};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rvalid ? bus_rdata : 16'hDEAD;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        e = bus_err;
        check("R10 no rvalid on write", 16'(bus_rvalid), 16'h0);
    endtask

    task automatic fill(input logic s, input int line);
        @(negedge clk);
        fill_done = 1'b1; fill_set = s; fill_line = LW'(line);
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(RB, rv);      check("R1 ctrl0", rv, 16'h0);
        bus_read(RB+2, rv);    check("R1 tag0", rv, 16'h0);
        bus_read(RB+4, rv);    check("R1 status", rv, 16'h0);
        bus_read(LVB, rv);     check("R1 lv word", rv, 16'h0);
        check("R1 rs_active", 16'(rs_active), 16'h0);

        // R2 / R4 table
        for (int i = 0; i < NV; i++) begin
            if (VW[i]) begin
                bus_write(VA[i], VD[i], ev);
                check("R2 R4 table write err", 16'(ev), VX[i]);
            end else begin
                bus_read(VA[i], rv);
                check("R2 R4 table read", rv, VX[i]);
            end
        end

        // R3 active gating
        @(negedge clk); cache_en = 1'b1;
        #1 check("R3 active with enable", 16'(rs_active), 16'h0001);
        @(negedge clk); cache_en = 1'b0;
        #1 check("R3 inactive without global", 16'(rs_active), 16'h0000);

        // R6 fills
        fill(1'b0, 17);
        bus_read(LVB+1, rv);   check("R6 line 17 position", rv, 16'h0002);
        bus_read(RB, rv);      check("R6 tv low while partial", rv, 16'h0003);
        for (int l = 0; l < LINES; l++) fill(1'b0, l);
        bus_read(RB, rv);      check("R6 tv after full fill", rv, 16'h8003);
        fill(1'b1, 5);
        bus_read(LVB+32, rv);  check("R6 ramset1 line 5", rv, 16'h0020);
        bus_read(LVB+4, rv);   check("R11 word beyond lines", rv, 16'h0);

        // R5 flush with masks: ramset0 flush=1, ramset1 flush=0
        bus_write(RB+1, 16'h0000, ev);
        @(negedge clk); cache_clr = 1'b1;
        @(negedge clk); cache_clr = 1'b0;
        bus_read(LVB+1, rv);   check("R5 flushed ramset lv", rv, 16'h0);
        bus_read(RB, rv);      check("R5 flushed tv", rv, 16'h0003);
        bus_read(LVB+32, rv);  check("R5 unflushed ramset kept", rv, 16'h0020);

        // R4 tag write clears lines
        bus_write(RB+3, 16'h0456, ev);
        bus_read(LVB+32, rv);  check("R4 tag write clears lv", rv, 16'h0);

        // R7 / R9 debug flag and read-clear
        debug_mode = 1'b1;
        bus_write(RB+1, 16'h0000, ev);
        debug_mode = 1'b0;
        emu_mode = 1'b1;
        bus_read(RB+4, rv);    check("R7 debug flag", rv, 16'h0002);
        bus_read(RB+4, rv);    check("R9 emu read keeps", rv, 16'h0002);
        emu_mode = 1'b0;
        bus_read(RB+4, rv);    check("R9 normal read value", rv, 16'h0002);
        bus_read(RB+4, rv);    check("R9 normal read clears", rv, 16'h0);

        // R8 tag clash
        bus_write(RB+3, 16'h7ABC, ev);
        check("R8 bus_err on clash", 16'(ev), 16'h1);
        bus_read(RB+3, rv);    check("R8 clashing tag stored", rv, 16'h7ABC);
        bus_read(RB+4, rv);    check("R8 status err bit", rv, 16'h0001);

        // R11 line-valid write rejected
        fill(1'b0, 3);
        bus_write(LVB, 16'hFFFF, ev);
        check("R11 bus_err on lv write", 16'(ev), 16'h1);
        bus_read(LVB, rv);     check("R11 lv write ignored", rv, 16'h0008);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule